// File: doc/BRIEF.md
# Spike-Timing Hebbian Weight Updater

This block keeps the synaptic weight matrix of a small time-multiplexed spiking network and adjusts it whenever a neuron fires. The neuron that fired is announced with its index, a role flag (acting as the pre-synaptic or the post-synaptic side) and the current value of a global tick counter. The block records that tick as the neuron's latest spike time. When learning is on, it then walks in ascending order through every other neuron connected to the one that fired. For each of them it takes the absolute tick difference between the two latest spikes and reads a potentiation value and, when chosen, a depression value from two exponential lookup tables. It then performs a read-modify-write of the weight with hard limits applied.

Weights are 12-bit two's complement numbers with 11 fractional bits, so one LSB is 2^-11, the most negative code -2048 is -1.0 and the most positive code 2047 is the upper limit. The potentiation amplitude is 32 LSB (2^-6) and decays with a time constant of 11.25 ticks. The depression term is either a constant 24 LSB (2^-7 + 2^-8) or a 24 LSB exponential decaying with 22.5 ticks. Every write is shown on a write-event port, and that port is the only view of the matrix.

Top module: `hebb_stdp_updater`

## Requirements
- R1: After reset all weights are 0, no neuron has a recorded spike time, `busy` is low and `wr_valid` is low.
- R2: A spike with `learn_en` high is accepted when `busy` is low and starts a scan. With `spk_post`=0 (pre role) of neuron k, the scan visits connections (post i, pre k). With `spk_post`=1 it visits (post k, pre j). Partners are visited in ascending index order, skipping k, and each partner takes exactly 3 cycles. The write of slot m is visible 2+3m cycles after the accepting edge, and `busy` stays high for 3·(N−1) cycles.
- R3: Every accepted spike stores `now` as the spike time of `spk_idx`. The lookup index for a partner is (now_at_accept − partner_time) mod 2^TS_W, saturated to LUT_DEPTH−1.
- R4: Window entry t (t < LUT_DEPTH−1) is floor(E_t / 65536), where E_0 = amplitude·65536 and E_{t+1} = floor(E_t·D / 65536). D is 59963 for potentiation (amplitude 32) and 62688 for depression (amplitude 24). Entry LUT_DEPTH−1 is 0.
- R5: With `dep_exp`=0 (latched at accept) the depression term is the constant 24. With `dep_exp`=1 it is the depression table entry at the same index.
- R6: The written weight is old + potentiation − depression, computed with guard bits and clamped to [−2048, 2047].
- R7: A weight equal to −2048 or 2047 is never written again, and its slot shows no write.
- R8: A partner with no recorded spike time since reset gets no write in its slot.
- R9: A self-connection (pre index equal to post index) is never written.
- R10: A spike offered while `busy` is high is ignored. It records no spike time, starts no scan and adds no write.
- R11: A spike accepted with `learn_en` low records its spike time only. `busy` stays low and no write follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| learn_en | input | 1 | Learning enable, sampled when a spike is accepted |
| dep_exp | input | 1 | Depression mode: 0 constant, 1 exponential; sampled at accept |
| spk_valid | input | 1 | A neuron fired this cycle |
| spk_idx | input | IDX_W (3) | Index of the neuron that fired |
| spk_post | input | 1 | Role of the firing neuron: 0 pre-synaptic, 1 post-synaptic |
| now | input | TS_W (16) | Global tick counter |
| busy | output | 1 | A scan is in progress; new spikes are ignored |
| wr_valid | output | 1 | A weight is written this cycle |
| wr_post | output | IDX_W (3) | Post-synaptic index of the written weight |
| wr_pre | output | IDX_W (3) | Pre-synaptic index of the written weight |
| wr_weight | output | W_W (12) | New weight value, Q1.11 two's complement |

## Verification
Spike acceptance and the read-modify-write of a running scan can occur in the same cycle. The bench offers a second spike, with a changed tick value, in the middle of a scan while writes are taking place. It then judges that spike as ignored in two ways. The running scan must keep its slot count and written values, computed from the tick latched at the first accept. A later scan that has the offered neuron as a partner must also see that partner as never having spiked.

// File: rtl/hebb_stdp_pkg.sv
package hebb_stdp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_CALC  = 2'd2,
    ST_WRITE = 2'd3
  } scan_state_t;

  // Exponential window entry: amplitude scaled by decay^idx (Q16 decay),
  // computed with a truncating fixed-point recurrence. The last entry is 0.
  function automatic int window_entry(input int amp, input int decay_q16,
                                      input int idx, input int depth);
    longint acc;
    if (idx >= depth - 1) return 0;
    acc = longint'(amp) <<< 16;
    for (int t = 0; t < idx; t++) begin
      acc = (acc * longint'(decay_q16)) >>> 16;
    end
    return int'(acc >>> 16);
  endfunction

endpackage

// File: rtl/hebb_window_rom.sv
module hebb_window_rom #(
  parameter int DEPTH     = 32,
  parameter int AMP       = 32,
  parameter int DECAY_Q16 = 59963,
  parameter int VAL_W     = 12,
  localparam int IW       = $clog2(DEPTH)
) (
  input  logic [IW-1:0]    idx,
  output logic [VAL_W-1:0] val
);
  import hebb_stdp_pkg::*;

  logic [VAL_W-1:0] tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    localparam int V = window_entry(AMP, DECAY_Q16, g, DEPTH);
    assign tbl[g] = VAL_W'(V);
  end

  assign val = tbl[idx];

endmodule

// File: rtl/hebb_stamp_table.sv
module hebb_stamp_table #(
  parameter int N_NEURON = 8,
  parameter int TS_W     = 16,
  localparam int IDX_W   = $clog2(N_NEURON)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TS_W-1:0]  wr_time,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TS_W-1:0]  rd_time,
  output logic             rd_seen
);
  logic [TS_W-1:0] stamp_q [N_NEURON];
  logic [N_NEURON-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      for (int i = 0; i < N_NEURON; i++) stamp_q[i] <= '0;
    end else if (wr_en) begin
      stamp_q[wr_idx] <= wr_time;
      seen_q[wr_idx]  <= 1'b1;
    end
  end

  assign rd_time = stamp_q[rd_idx];
  assign rd_seen = seen_q[rd_idx];

endmodule

// File: rtl/hebb_weight_ram.sv
module hebb_weight_ram #(
  parameter int DEPTH = 64,
  parameter int W_W   = 12,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd_en,
  input  logic [AW-1:0]  rd_addr,
  output logic [W_W-1:0] rd_data,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [W_W-1:0] wr_data
);
  logic [W_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) rd_data <= mem_q[rd_addr];
  end

endmodule

// File: rtl/hebb_scan_ctrl.sv
module hebb_scan_ctrl #(
  parameter int N_NEURON = 8,
  localparam int IDX_W   = $clog2(N_NEURON),
  localparam int CW      = IDX_W + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        spk_valid,
  input  logic                        learn_en,
  input  logic [IDX_W-1:0]            spk_idx,
  input  logic                        spk_post,
  output logic                        evt_accept,
  output hebb_stdp_pkg::scan_state_t  scan_state,
  output logic [IDX_W-1:0]            owner,
  output logic [IDX_W-1:0]            partner,
  output logic                        role_post,
  output logic                        busy
);
  import hebb_stdp_pkg::*;

  scan_state_t     state_q;
  logic [IDX_W-1:0] owner_q;
  logic [CW-1:0]    partner_q;
  logic             role_q;
  logic [CW-1:0]    first_partner;
  logic [CW-1:0]    next_partner;
  logic             last_slot;

  assign evt_accept    = spk_valid && (state_q == ST_IDLE);
  assign first_partner = (spk_idx == '0) ? CW'(1) : CW'(0);

  always_comb begin
    next_partner = partner_q + CW'(1);
    if (next_partner == {1'b0, owner_q}) next_partner = next_partner + CW'(1);
  end
  assign last_slot = (next_partner >= CW'(N_NEURON));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      owner_q   <= '0;
      partner_q <= '0;
      role_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (evt_accept) begin
            owner_q   <= spk_idx;
            role_q    <= spk_post;
            partner_q <= first_partner;
            if (learn_en) state_q <= ST_READ;
          end
        end
        ST_READ:  state_q <= ST_CALC;
        ST_CALC:  state_q <= ST_WRITE;
        ST_WRITE: begin
          if (last_slot) begin
            state_q <= ST_IDLE;
          end else begin
            partner_q <= next_partner;
            state_q   <= ST_READ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign scan_state = state_q;
  assign owner      = owner_q;
  assign partner    = partner_q[IDX_W-1:0];
  assign role_post  = role_q;
  assign busy       = (state_q != ST_IDLE);

endmodule

// File: rtl/hebb_stdp_updater.sv
module hebb_stdp_updater #(
  parameter int N_NEURON  = 8,
  parameter int TS_W      = 16,
  parameter int LUT_DEPTH = 32,
  parameter int W_W       = 12,
  parameter int A_PLUS    = 32,
  parameter int A_MINUS   = 24,
  parameter int DECAY_P   = 59963,
  parameter int DECAY_M   = 62688,
  localparam int IDX_W    = $clog2(N_NEURON),
  localparam int NCONN    = N_NEURON * N_NEURON,
  localparam int AW       = $clog2(NCONN),
  localparam int LIW      = $clog2(LUT_DEPTH),
  localparam int SW       = W_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             learn_en,
  input  logic             dep_exp,
  input  logic             spk_valid,
  input  logic [IDX_W-1:0] spk_idx,
  input  logic             spk_post,
  input  logic [TS_W-1:0]  now,
  output logic             busy,
  output logic             wr_valid,
  output logic [IDX_W-1:0] wr_post,
  output logic [IDX_W-1:0] wr_pre,
  output logic [W_W-1:0]   wr_weight
);
  import hebb_stdp_pkg::*;

  localparam logic signed [W_W-1:0] WMAX = {1'b0, {(W_W-1){1'b1}}};
  localparam logic signed [W_W-1:0] WMIN = {1'b1, {(W_W-1){1'b0}}};

  // Guarded sum, then clamp back to the weight range.
  function automatic logic [W_W-1:0] clamp_weight(input logic signed [SW-1:0] s);
    if (s > SW'(WMAX))      return WMAX;
    else if (s < SW'(WMIN)) return WMIN;
    else                    return s[W_W-1:0];
  endfunction

  function automatic logic at_limit(input logic [W_W-1:0] w);
    return (w == WMAX) || (w == WMIN);
  endfunction

  function automatic logic [AW-1:0] conn_addr(input logic [IDX_W-1:0] post,
                                               input logic [IDX_W-1:0] pre);
    return AW'(int'(post) * N_NEURON + int'(pre));
  endfunction

  function automatic logic [LIW-1:0] sat_index(input logic [TS_W-1:0] diff);
    if (diff >= TS_W'(LUT_DEPTH - 1)) return LIW'(LUT_DEPTH - 1);
    else                               return diff[LIW-1:0];
  endfunction

  // Scan control
  logic             evt_accept;
  scan_state_t      scan_state;
  logic [IDX_W-1:0] owner;
  logic [IDX_W-1:0] partner;
  logic             role_post;

  hebb_scan_ctrl #(.N_NEURON(N_NEURON)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .spk_valid  (spk_valid),
    .learn_en   (learn_en),
    .spk_idx    (spk_idx),
    .spk_post   (spk_post),
    .evt_accept (evt_accept),
    .scan_state (scan_state),
    .owner      (owner),
    .partner    (partner),
    .role_post  (role_post),
    .busy       (busy)
  );

  // Latched event context
  logic [TS_W-1:0] now_q;
  logic            dep_exp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q     <= '0;
      dep_exp_q <= 1'b0;
    end else if (evt_accept) begin
      now_q     <= now;
      dep_exp_q <= dep_exp;
    end
  end

  // Spike-time table
  logic [TS_W-1:0] partner_time;
  logic            partner_seen;

  hebb_stamp_table #(.N_NEURON(N_NEURON), .TS_W(TS_W)) u_stamps (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (evt_accept),
    .wr_idx  (spk_idx),
    .wr_time (now),
    .rd_idx  (partner),
    .rd_time (partner_time),
    .rd_seen (partner_seen)
  );

  // Connection being visited
  logic [IDX_W-1:0] cur_post;
  logic [IDX_W-1:0] cur_pre;
  assign cur_post = role_post ? owner : partner;
  assign cur_pre  = role_post ? partner : owner;

  // Read stage registers
  logic [LIW-1:0]   dt_idx_q;
  logic             pseen_q;
  logic [IDX_W-1:0] post_q;
  logic [IDX_W-1:0] pre_q;
  logic             in_read;
  logic             in_calc;
  logic             in_write;

  assign in_read  = (scan_state == ST_READ);
  assign in_calc  = (scan_state == ST_CALC);
  assign in_write = (scan_state == ST_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dt_idx_q <= '0;
      pseen_q  <= 1'b0;
      post_q   <= '0;
      pre_q    <= '0;
    end else if (in_read) begin
      dt_idx_q <= sat_index(now_q - partner_time);
      pseen_q  <= partner_seen;
      post_q   <= cur_post;
      pre_q    <= cur_pre;
    end
  end

  // Weight storage
  logic [W_W-1:0] rd_data;
  logic [W_W-1:0] new_w_q;
  logic           do_wr_q;
  logic           ram_we;

  assign ram_we = in_write && do_wr_q;

  hebb_weight_ram #(.DEPTH(NCONN), .W_W(W_W)) u_ram (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (in_read),
    .rd_addr (conn_addr(cur_post, cur_pre)),
    .rd_data (rd_data),
    .wr_en   (ram_we),
    .wr_addr (conn_addr(post_q, pre_q)),
    .wr_data (new_w_q)
  );

  // Learning window tables
  logic [W_W-1:0] pot_val;
  logic [W_W-1:0] dep_exp_val;

  hebb_window_rom #(.DEPTH(LUT_DEPTH), .AMP(A_PLUS), .DECAY_Q16(DECAY_P),
                    .VAL_W(W_W)) u_rom_pot (
    .idx (dt_idx_q),
    .val (pot_val)
  );

  hebb_window_rom #(.DEPTH(LUT_DEPTH), .AMP(A_MINUS), .DECAY_Q16(DECAY_M),
                    .VAL_W(W_W)) u_rom_dep (
    .idx (dt_idx_q),
    .val (dep_exp_val)
  );

  // Calculate stage
  logic [W_W-1:0]        dep_val;
  logic signed [SW-1:0]  sum_g;
  logic [W_W-1:0]        old_w_q;

  assign dep_val = dep_exp_q ? dep_exp_val : W_W'(A_MINUS);
  assign sum_g   = $signed({{2{rd_data[W_W-1]}}, rd_data})
                 + $signed({2'b00, pot_val})
                 - $signed({2'b00, dep_val});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      new_w_q <= '0;
      do_wr_q <= 1'b0;
      old_w_q <= '0;
    end else if (in_calc) begin
      new_w_q <= clamp_weight(sum_g);
      do_wr_q <= pseen_q && !at_limit(rd_data);
      old_w_q <= rd_data;
    end
  end

  // Write-event port
  assign wr_valid  = ram_we;
  assign wr_post   = post_q;
  assign wr_pre    = pre_q;
  assign wr_weight = new_w_q;

endmodule

// File: rtl/hebb_stdp_updater_chk.sv
module hebb_stdp_updater_chk #(
  parameter int IDX_W   = 3,
  parameter int W_W     = 12,
  parameter int A_PLUS  = 32,
  parameter int A_MINUS = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             spk_valid,
  input logic             learn_en,
  input logic             busy,
  input logic             evt_accept,
  input logic             wr_valid,
  input logic [IDX_W-1:0] wr_post,
  input logic [IDX_W-1:0] wr_pre,
  input logic [W_W-1:0]   wr_weight,
  input logic [W_W-1:0]   old_w
);
  localparam logic [W_W-1:0] WMAX = {1'b0, {(W_W-1){1'b1}}};
  localparam logic [W_W-1:0] WMIN = {1'b1, {(W_W-1){1'b0}}};

  logic signed [W_W+1:0] delta;
  assign delta = $signed({{2{wr_weight[W_W-1]}}, wr_weight})
               - $signed({{2{old_w[W_W-1]}}, old_w});

  a_r9_no_self: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_post != wr_pre));

  a_r7_limit_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (old_w != WMAX && old_w != WMIN));

  a_r6_step_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (delta <= (W_W+2)'(A_PLUS) && delta >= -(W_W+2)'(A_MINUS)));

  a_r2_scan_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_accept && learn_en) |=> busy);

  a_r2_write_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  a_r2_write_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> busy);

  a_r10_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !evt_accept);

  a_r11_off_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_accept && !learn_en) |=> !busy);

  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !spk_valid) |=> !wr_valid);

endmodule

bind hebb_stdp_updater hebb_stdp_updater_chk #(
  .IDX_W(IDX_W), .W_W(W_W), .A_PLUS(A_PLUS), .A_MINUS(A_MINUS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .spk_valid  (spk_valid),
  .learn_en   (learn_en),
  .busy       (busy),
  .evt_accept (evt_accept),
  .wr_valid   (wr_valid),
  .wr_post    (wr_post),
  .wr_pre     (wr_pre),
  .wr_weight  (wr_weight),
  .old_w      (old_w_q)
);

// File: tb/hebb_stdp_updater_bench.sv
module hebb_stdp_updater_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NN   = 8;
  localparam int LAST = 31;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       learn_en = 1'b0;
  logic       dep_exp = 1'b0;
  logic       spk_valid = 1'b0;
  logic [2:0] spk_idx = '0;
  logic       spk_post = 1'b0;
  logic [15:0] now = '0;
  logic       busy;
  logic       wr_valid;
  logic [2:0] wr_post;
  logic [2:0] wr_pre;
  logic [11:0] wr_weight;

  hebb_stdp_updater u_hebb_stdp_updater (
    .clk(clk), .rst_n(rst_n), .learn_en(learn_en), .dep_exp(dep_exp),
    .spk_valid(spk_valid), .spk_idx(spk_idx), .spk_post(spk_post), .now(now),
    .busy(busy), .wr_valid(wr_valid), .wr_post(wr_post), .wr_pre(wr_pre),
    .wr_weight(wr_weight)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;

  int mw [NN][NN];
  int mst [NN];
  bit mseen [NN];
  int obs_w [NN][NN];
  int obs_cnt [NN][NN];
  int ex_valid [NN];
  int ex_post [NN];
  int ex_pre [NN];
  int ex_w [NN];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Window value restated from the requirement text.
  function automatic int bwin(input int amp, input int dq, input int t);
    longint e;
    if (t >= LAST) return 0;
    e = longint'(amp) * 65536;
    for (int s = 0; s < t; s++) e = (e * dq) / 65536;
    return int'(e / 65536);
  endfunction

  function automatic int bclamp(input int v);
    if (v > 2047) return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  task automatic spike(input int idx, input bit post, input int tnow,
                       input bit le, input bit dexp, input int inj,
                       input string tag);
    int m;
    int bad_c;
    m = 0;
    for (int p = 0; p < NN; p++) begin
      if (p != idx) begin
        int pi, qi, w, dt, ix, pot, dep;
        pi = post ? idx : p;
        qi = post ? p : idx;
        ex_post[m] = pi;
        ex_pre[m] = qi;
        ex_valid[m] = 0;
        if (le && mseen[p]) begin
          w = mw[pi][qi];
          if (w != 2047 && w != -2048) begin
            dt = (tnow - mst[p]) & 32'hFFFF;
            ix = (dt >= LAST) ? LAST : dt;
            pot = bwin(32, 59963, ix);
            dep = dexp ? bwin(24, 62688, ix) : 24;
            ex_valid[m] = 1;
            ex_w[m] = bclamp(w + pot - dep);
            mw[pi][qi] = ex_w[m];
          end
        end
        m++;
      end
    end
    mst[idx] = tnow;
    mseen[idx] = 1'b1;

    @(negedge clk);
    spk_valid = 1'b1; spk_idx = 3'(idx); spk_post = post;
    now = 16'(tnow); learn_en = le; dep_exp = dexp;
    bad_c = -1;
    for (int c = 0; c <= 3*NN+2; c++) begin
      bit slot;
      int k;
      @(negedge clk);
      if (busy !== (le && c < 3*(NN-1)) && bad_c < 0) bad_c = c;
      slot = le && c >= 2 && ((c-2) % 3 == 0) && ((c-2)/3 < NN-1);
      k = (c-2)/3;
      if (wr_valid) begin
        obs_w[wr_post][wr_pre] = int'($signed(wr_weight));
        obs_cnt[wr_post][wr_pre]++;
        chk(wr_pre != wr_post, "R9", "self write", int'(wr_pre), -1);
      end
      if (slot) begin
        chk(wr_valid == ex_valid[k], tag, "slot write flag", int'(wr_valid), ex_valid[k]);
        if (wr_valid && ex_valid[k]) begin
          chk(int'(wr_post) == ex_post[k] && int'(wr_pre) == ex_pre[k], tag,
              "slot connection", int'(wr_post)*8+int'(wr_pre), ex_post[k]*8+ex_pre[k]);
          chk(int'($signed(wr_weight)) == ex_w[k], tag, "slot weight",
              int'($signed(wr_weight)), ex_w[k]);
        end
      end else if (wr_valid) begin
        chk(1'b0, tag, "write outside slot", c, -1);
      end
      if (c == 0) spk_valid = 1'b0;
      if (inj >= 0 && c == 4) begin
        spk_valid = 1'b1; spk_idx = 3'(inj); spk_post = ~post;
        now = 16'(tnow + 7); dep_exp = ~dexp;
      end
      if (inj >= 0 && c == 5) spk_valid = 1'b0;
    end
    chk(bad_c < 0, le ? "R2" : "R11", "busy profile first bad cycle", bad_c, -1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int t;
    int cnt_before;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NN; i++) begin
      mst[i] = 0; mseen[i] = 1'b0;
      for (int j = 0; j < NN; j++) begin
        mw[i][j] = 0; obs_w[i][j] = 0; obs_cnt[i][j] = 0;
      end
    end

    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
    chk(wr_valid == 1'b0, "R1", "wr_valid in reset", int'(wr_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);

    // Directed cases
    spike(0, 1'b0, 100, 1'b1, 1'b0, -1, "R8");   // no partner has spiked
    spike(1, 1'b1, 103, 1'b1, 1'b0, -1, "R1");   // W(1,0) updated from 0
    spike(2, 1'b1, 103, 1'b1, 1'b1, -1, "R5");   // exponential depression
    spike(3, 1'b0, 110, 1'b0, 1'b0, -1, "R11");  // learning off
    spike(4, 1'b1, 500, 1'b1, 1'b0, -1, "R3");   // saturated index
    spike(5, 1'b0, 505, 1'b1, 1'b1, 6, "R10");   // spike offered mid-scan
    spike(7, 1'b0, 515, 1'b1, 1'b0, -1, "R10");  // partner 6 must be unseen
    spike(6, 1'b1, 520, 1'b1, 1'b0, -1, "R3");
    spike(0, 1'b0, 600, 1'b1, 1'b0, -1, "R4");
    spike(1, 1'b1, 605, 1'b1, 1'b1, -1, "R4");
    spike(4, 1'b0, 606, 1'b1, 1'b1, -1, "R4");

    // Upper limit on W(1,0)
    t = 1000;
    for (int n = 0; n < 260; n++) begin
      spike(0, 1'b0, t, 1'b1, 1'b0, -1, "R6");
      spike(1, 1'b1, t, 1'b1, 1'b0, -1, "R6");
      t++;
    end
    chk(obs_w[1][0] == 2047, "R6", "upper clamp W(1,0)", obs_w[1][0], 2047);
    cnt_before = obs_cnt[1][0];
    spike(0, 1'b0, t, 1'b1, 1'b0, -1, "R7");
    spike(1, 1'b1, t, 1'b1, 1'b0, -1, "R7");
    chk(obs_cnt[1][0] == cnt_before, "R7", "writes to frozen W(1,0)",
        obs_cnt[1][0], cnt_before);

    // Lower limit on W(2,3)
    t = 2000;
    for (int n = 0; n < 60; n++) begin
      spike(3, 1'b0, t, 1'b1, 1'b0, -1, "R6");
      spike(2, 1'b1, t + 100, 1'b1, 1'b0, -1, "R6");
      t += 200;
    end
    chk(obs_w[2][3] == -2048, "R6", "lower clamp W(2,3)", obs_w[2][3], -2048);
    cnt_before = obs_cnt[2][3];
    spike(2, 1'b1, t, 1'b1, 1'b1, -1, "R7");
    chk(obs_cnt[2][3] == cnt_before, "R7", "writes to frozen W(2,3)",
        obs_cnt[2][3], cnt_before);

    // Constrained random phase
    t = 15000;
    for (int n = 0; n < 250; n++) begin
      int idx, inj;
      bit le, post, dx;
      idx  = int'($urandom % NN);
      post = 1'($urandom % 2);
      dx   = 1'($urandom % 2);
      le   = (($urandom % 8) != 0);
      inj  = (le && (($urandom % 6) == 0)) ? int'($urandom % NN) : -1;
      t    = t + int'($urandom % 40);
      spike(idx, post, t, le, dx, inj, "R2");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule